// File: doc/BRIEF.md
# Multiframe DCC Byte Inserter

This block keeps a bank of section data-communication-channel bytes for a 24-frame multiframe (three bytes per frame, 72 in all) and places them into the three DCC byte slots (D1, D2, D3) of each outgoing frame. Outside those slots, and whenever insertion is switched off, the transmit byte stream passes through unchanged.

A host fills the bank with a stream of byte writes. The first write after reset or after a status clear goes to frame 0, slot D1. The pointer then steps through D2 and D3 and on to the next frame, up to frame 23, slot D3. When the transmitter has sent all 24 frames of a multiframe, a sticky ready flag is raised, and an interrupt follows unless it is masked. This tells the host that the next block of bytes may be written. If the host does not rewrite the bank, the same bytes are sent again in the next multiframe.

The frame timing comes from two kinds of input. A frame-start strobe moves the frame index forward, and three one-hot position strobes mark the D1, D2 and D3 byte times within the current frame. Reset places the block at frame 0.

Top module: `dcc_mframe_inserter`

## Requirements
- R1: After reset the frame index is 0, the write pointer is 0, `ready_sts` and `irq` are 0, and the bank reads 0.
- R2: Each cycle with `hst_wvld` high stores `hst_wdata` at the write pointer and then moves the pointer on by one. Byte n (0..71) belongs to frame n/3, slot n%3. After byte 71 the pointer returns to 0, so a 73rd write replaces byte 0.
- R3: With `ins_enable` high and a position strobe active, `data_out` shows bank byte (frame index × 3 + slot) in the same cycle. `dpos` bit 0 selects slot 0 (D1), bit 1 selects slot 1 (D2) and bit 2 selects slot 2 (D3). At most one bit may be high.
- R4: With `dpos` equal to 0, `data_out` equals `data_in`.
- R5: With `ins_enable` low, `data_out` equals `data_in` in every slot, and the frame index keeps advancing on `frame_start`.
- R6: Each `frame_start` pulse advances the frame index by one. After index 23 it wraps to 0. Without a pulse, the index holds.
- R7: A `frame_start` pulse that arrives while the index is 23 sets `ready_sts` on the following cycle. The flag stays set until the host clears it.
- R8: `irq` equals `ready_sts` AND NOT `irq_mask`.
- R9: A `hst_rdy_clr` pulse clears `ready_sts` and resets the write pointer to 0. If the pulse falls in the same cycle as the multiframe end from R7, setting the flag wins.
- R10: If the host writes nothing, every later multiframe sends the same bytes again.
- R11: A data write in the same cycle as `hst_rdy_clr` is stored at byte 0, and the pointer moves on to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse at each new transmit frame |
| dpos | input | 3 | One-hot D1/D2/D3 byte-time strobes |
| data_in | input | DW | Transmit byte stream before insertion |
| data_out | output | DW | Transmit byte stream after insertion |
| ins_enable | input | 1 | 1 = insert bank bytes, 0 = pass through |
| irq_mask | input | 1 | 1 = interrupt masked |
| hst_wvld | input | 1 | Host byte write strobe |
| hst_wdata | input | DW | Host byte |
| hst_rdy_clr | input | 1 | Host write-1-to-clear of the ready flag |
| ready_sts | output | 1 | Sticky multiframe-complete flag |
| irq | output | 1 | Ready interrupt |

## Verification
The bench fills the bank with an arithmetic pattern that has 72 distinct values and then checks every slot of every frame across several multiframes. An address built as frame + slot instead of frame × 3 + slot, or a frame counter that wraps at the wrong point, therefore shows up as a wrong byte.

It also covers the following cases, and the fault each one would expose:
- A 73rd write: a pointer that does not wrap would never replace byte 0.
- Five frames with insertion disabled: an index that froze during that time would be off by five afterwards.
- A write in the same cycle as a clear: mishandling would put that byte at the old pointer.
- A clear that meets the multiframe end: if the clear won, that multiframe's ready flag would be lost.

// File: rtl/dcc_ins_pkg.sv
// Shared constants and helpers for the multiframe DCC byte inserter.
// Assumes the three DCC slots per frame are fixed by the frame format.
package dcc_ins_pkg;
    localparam int NUM_SLOTS = 3;
    localparam logic [1:0] SLOT_NONE = 2'd3;

    // Map the one-hot D1/D2/D3 strobes to a slot number; lowest bit wins.
    function automatic logic [1:0] decode_slot(input logic [2:0] pos);
        if (pos[0])      return 2'd0;
        else if (pos[1]) return 2'd1;
        else if (pos[2]) return 2'd2;
        else             return SLOT_NONE;
    endfunction
endpackage

// File: rtl/dcc_frame_ctr.sv
// Frame index within the multiframe. Advances on frame_start and wraps after
// FRAMES-1. Flags the strobe that closes a multiframe.
// Assumes frame_start is a single-cycle pulse.
module dcc_frame_ctr #(
    parameter int FRAMES = 24,
    parameter int IW     = $clog2(FRAMES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    output logic [IW-1:0] idx,
    output logic          mf_done
);
    localparam logic [IW-1:0] LAST = IW'(FRAMES - 1);

    // Index register: step on each frame strobe, wrap after the last frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= '0;
        else if (frame_start)
            idx <= (idx == LAST) ? '0 : idx + 1'b1;
    end

    // The last frame of the multiframe has been sent when its successor starts.
    assign mf_done = frame_start && (idx == LAST);
endmodule

// File: rtl/dcc_byte_bank.sv
// Byte store for one multiframe of DCC bytes, with a sequential host write
// pointer and a combinational read port.
// Assumes rd_addr stays below DEPTH. A pointer reset in the same cycle as a
// write sends that write to address 0.
module dcc_byte_bank #(
    parameter int DEPTH = 72,
    parameter int DW    = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_vld,
    input  logic [DW-1:0] wr_data,
    input  logic          ptr_rst,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] wr_ptr
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_addr;

    // Effective write address: a pointer reset redirects a same-cycle write to 0.
    assign wr_addr = ptr_rst ? '0 : wr_ptr;

    // Write pointer: step past each stored byte, wrap at the end, restart on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_ptr <= '0;
        else if (wr_vld)
            wr_ptr <= (wr_addr == LAST) ? '0 : wr_addr + 1'b1;
        else if (ptr_rst)
            wr_ptr <= '0;
    end

    // Storage rows: clear on reset, load the addressed row on a host write.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n)
                mem[i] <= '0;
            else if (wr_vld && (wr_addr == AW'(i)))
                mem[i] <= wr_data;
        end
    end

    // Read port: the addressed byte, available in the same cycle.
    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/dcc_ready_irq.sv
// Sticky multiframe-ready flag with write-1-to-clear and a masked interrupt.
// Assumes set has priority over clear so that no multiframe end is lost.
module dcc_ready_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic mask,
    output logic ready,
    output logic irq
);
    // Flag register: set at the multiframe end, cleared by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ready <= 1'b0;
        else if (set)
            ready <= 1'b1;
        else if (clr)
            ready <= 1'b0;
    end

    // Interrupt line: the flag gated by the mask.
    assign irq = ready & ~mask;
endmodule

// File: rtl/dcc_mframe_inserter.sv
// Multiframe DCC byte inserter top. Replaces the D1/D2/D3 bytes of each frame
// with host-supplied bank bytes for frame index*3+slot, and raises a ready
// interrupt after each full multiframe.
// Assumes dpos is one-hot or zero, and that reset marks the start of frame 0.
module dcc_mframe_inserter #(
    parameter int FRAMES = 24,
    parameter int DW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic [2:0]    dpos,
    input  logic [DW-1:0] data_in,
    output logic [DW-1:0] data_out,
    input  logic          ins_enable,
    input  logic          irq_mask,
    input  logic          hst_wvld,
    input  logic [DW-1:0] hst_wdata,
    input  logic          hst_rdy_clr,
    output logic          ready_sts,
    output logic          irq
);
    import dcc_ins_pkg::*;

    localparam int DEPTH = FRAMES * NUM_SLOTS;
    localparam int AW    = $clog2(DEPTH);
    localparam int IW    = $clog2(FRAMES);

    logic [IW-1:0] frm_idx;
    logic          mf_done;
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] bank_q;
    logic [1:0]    slot;
    logic          in_slot;

    dcc_frame_ctr #(.FRAMES(FRAMES), .IW(IW)) u_frame (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .idx(frm_idx), .mf_done(mf_done)
    );

    dcc_byte_bank #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_vld(hst_wvld), .wr_data(hst_wdata),
        .ptr_rst(hst_rdy_clr), .rd_addr(rd_addr), .rd_data(bank_q),
        .wr_ptr(wr_ptr)
    );

    dcc_ready_irq u_rdy (
        .clk(clk), .rst_n(rst_n), .set(mf_done), .clr(hst_rdy_clr),
        .mask(irq_mask), .ready(ready_sts), .irq(irq)
    );

    // Slot decode from the byte-position strobes.
    assign slot    = decode_slot(dpos);
    assign in_slot = (slot != SLOT_NONE);

    // Bank address: three bytes per frame, slot offset only inside a DCC slot.
    assign rd_addr = AW'(frm_idx) * AW'(NUM_SLOTS) + (in_slot ? AW'(slot) : '0);

    // Output mux: bank byte in enabled DCC slots, the incoming stream elsewhere.
    assign data_out = (ins_enable && in_slot) ? bank_q : data_in;
endmodule

// File: rtl/dcc_ins_checker.sv
// Assertion checker for dcc_mframe_inserter, attached by bind below.
// Observes ports plus the frame index and write pointer of the top.
module dcc_ins_checker #(
    parameter int FRAMES = 24,
    parameter int DW     = 8,
    parameter int IW     = $clog2(FRAMES),
    parameter int AW     = $clog2(FRAMES * 3)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frame_start,
    input logic [2:0]    dpos,
    input logic [DW-1:0] data_in,
    input logic [DW-1:0] data_out,
    input logic          ins_enable,
    input logic          irq_mask,
    input logic          hst_wvld,
    input logic          hst_rdy_clr,
    input logic          ready_sts,
    input logic          irq,
    input logic [IW-1:0] frm_idx,
    input logic [AW-1:0] wr_ptr
);
    localparam logic [IW-1:0] LAST_F = IW'(FRAMES - 1);
    localparam logic [AW-1:0] LAST_B = AW'(FRAMES * 3 - 1);

    AST_DPOS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(dpos)); // R3
    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n) (dpos == 3'b000) |-> (data_out == data_in)); // R4
    AST_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n) !ins_enable |-> (data_out == data_in)); // R5
    AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (frame_start && frm_idx == LAST_F) |=> (frm_idx == '0)); // R6
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !frame_start |=> $stable(frm_idx)); // R6
    AST_RDY_SET: assert property (@(posedge clk) disable iff (!rst_n) (frame_start && frm_idx == LAST_F) |=> ready_sts); // R7
    AST_RDY_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (ready_sts && !hst_rdy_clr) |=> ready_sts); // R7
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n) irq_mask |-> !irq); // R8
    AST_IRQ_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n) irq |-> ready_sts); // R8
    AST_RDY_CLR: assert property (@(posedge clk) disable iff (!rst_n) (hst_rdy_clr && !(frame_start && frm_idx == LAST_F)) |=> !ready_sts); // R9
    AST_PTR_CLR: assert property (@(posedge clk) disable iff (!rst_n) (hst_rdy_clr && !hst_wvld) |=> (wr_ptr == '0)); // R9
    AST_PTR_CLR_WR: assert property (@(posedge clk) disable iff (!rst_n) (hst_rdy_clr && hst_wvld) |=> (wr_ptr == AW'(1))); // R11
    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (hst_wvld && !hst_rdy_clr && wr_ptr == LAST_B) |=> (wr_ptr == '0)); // R2
endmodule

bind dcc_mframe_inserter dcc_ins_checker #(.FRAMES(FRAMES), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .dpos(dpos),
    .data_in(data_in), .data_out(data_out), .ins_enable(ins_enable),
    .irq_mask(irq_mask), .hst_wvld(hst_wvld), .hst_rdy_clr(hst_rdy_clr),
    .ready_sts(ready_sts), .irq(irq), .frm_idx(frm_idx), .wr_ptr(wr_ptr)
);

// File: tb/sim_dcc_mframe_inserter.sv
// Bench: near-exhaustive slot sweep over several multiframes, with an
// arithmetic reference of the bank, pointer, frame index and ready flag.
module sim_dcc_mframe_inserter;
    localparam int FR = 24;
    localparam int NB = FR * 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic [2:0] dpos = 3'b000;
    logic [7:0] data_in = 8'h00;
    logic [7:0] data_out;
    logic       ins_enable = 1'b1;
    logic       irq_mask = 1'b1;
    logic       hst_wvld = 1'b0;
    logic [7:0] hst_wdata = 8'h00;
    logic       hst_rdy_clr = 1'b0;
    logic       ready_sts;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_mem [NB];
    int exp_ptr = 0;
    int exp_idx = 0;
    bit exp_rdy = 0;

    always #4 clk = ~clk;

    dcc_mframe_inserter #(.FRAMES(FR), .DW(8)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .dpos(dpos),
        .data_in(data_in), .data_out(data_out), .ins_enable(ins_enable),
        .irq_mask(irq_mask), .hst_wvld(hst_wvld), .hst_wdata(hst_wdata),
        .hst_rdy_clr(hst_rdy_clr), .ready_sts(ready_sts), .irq(irq)
    );

    function automatic logic [7:0] pat(input int seed, input int n);
        return 8'((n * 29 + seed * 71 + 3) & 255);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic host_wr(input logic [7:0] b, input bit clr);
        int a;
        @(negedge clk);
        hst_wvld = 1'b1; hst_wdata = b; hst_rdy_clr = clr;
        a = clr ? 0 : exp_ptr;
        exp_mem[a] = b;
        exp_ptr = (a + 1) % NB;
        if (clr) exp_rdy = 0;
        @(negedge clk);
        hst_wvld = 1'b0; hst_rdy_clr = 1'b0;
    endtask

    task automatic clr_only;
        @(negedge clk);
        hst_rdy_clr = 1'b1;
        exp_rdy = 0; exp_ptr = 0;
        @(negedge clk);
        hst_rdy_clr = 1'b0;
    endtask

    task automatic frame_tick(input bit clr);
        @(negedge clk);
        frame_start = 1'b1; hst_rdy_clr = clr;
        if (clr) begin exp_rdy = 0; exp_ptr = 0; end
        if (exp_idx == FR - 1) exp_rdy = 1;
        exp_idx = (exp_idx + 1) % FR;
        @(negedge clk);
        frame_start = 1'b0; hst_rdy_clr = 1'b0;
    endtask

    task automatic check_status(input string req);
        @(negedge clk);
        #1;
        chk(req, int'(ready_sts), int'(exp_rdy));
        chk("R8", int'(irq), int'(exp_rdy & ~irq_mask));
    endtask

    task automatic check_slot(input int s, input logic [7:0] din, input string req);
        logic [7:0] e;
        @(negedge clk);
        dpos = 3'(1 << s); data_in = din;
        #1;
        e = ins_enable ? exp_mem[exp_idx * 3 + s] : din;
        chk(req, int'(data_out), int'(e));
        #1;
        dpos = 3'b000;
    endtask

    task automatic check_idle(input logic [7:0] din);
        @(negedge clk);
        dpos = 3'b000; data_in = din;
        #1;
        chk("R4", int'(data_out), int'(din));
    endtask

    task automatic run_frames(input int n, input string req);
        for (int f = 0; f < n; f++) begin
            for (int s = 0; s < 3; s++)
                check_slot(s, 8'((exp_idx * 3 + s) ^ 8'hC3), req);
            check_idle(8'(f + 8'h40));
            frame_tick(1'b0);
            check_status("R7");
        end
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        for (int i = 0; i < NB; i++) exp_mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_status("R1");
        check_slot(0, 8'hA5, "R1");
        check_idle(8'h5A);
        // R2/R3: full fill then sweep of every slot
        for (int n = 0; n < NB; n++) host_wr(pat(1, n), 1'b0);
        run_frames(FR, "R3");
        irq_mask = 1'b0;
        check_status("R8");
        // R10: no rewrite, same bytes again; flag stays set
        run_frames(FR, "R10");
        // R9: clear flag and pointer
        clr_only();
        check_status("R9");
        // R2: 72 writes plus a 73rd that replaces byte 0
        for (int n = 0; n < NB; n++) host_wr(pat(2, n), 1'b0);
        host_wr(8'hEE, 1'b0);
        run_frames(FR, "R2");
        // R5: disabled for five frames, index must keep counting
        ins_enable = 1'b0;
        run_frames(5, "R5");
        ins_enable = 1'b1;
        run_frames(FR - 5, "R5");
        // R11: write together with clear lands at byte 0, next at byte 1
        host_wr(8'h11, 1'b1);
        host_wr(8'h22, 1'b0);
        check_status("R9");
        run_frames(FR, "R11");
        // R9: clear meets multiframe end, set wins
        run_frames(FR - 1, "R6");
        frame_tick(1'b1);
        check_status("R9");
        host_wr(8'h77, 1'b0);
        check_slot(0, 8'h00, "R9");
        irq_mask = 1'b1;
        check_status("R8");
        report();
    end
endmodule